// File: doc/BRIEF.md
# Card Bus Timing and Sample-Tap Control Register

This block is a single software-writable control word for a card host controller. It holds the bus timing mode used by the datapath. It also holds a requested receive sampling tap. The mode field takes effect on the clock edge after a write. Unused mode codes are folded to the SD/legacy mode.

The tap field does not reach the receive path when it is written. It is applied only when a write also sets the update request bit. That bit stays readable as 1 for a fixed number of cycles and then clears itself. The new tap appears on the output in the same cycle that the bit clears.

Software writes the tap together with the update bit and polls until the bit reads 0. The delay line supports fewer taps than the 6-bit field can encode. Requests at or above the tap count wrap back to the bottom of the range.

Top module: `tune_ctrl_top`

## Requirements
- R1: After reset, the register reads 0, `mode_o` is 0 and `tap_o` is 0.
- R2: Bits 2:0 select the mode with these codes: 0 SD/legacy, 2 MMC SDR, 3 MMC DDR, 4 HS200, 5 HS400, 6 HS400 enhanced strobe. A write changes `mode_o` on the clock edge that samples the write, and the value is visible one cycle later.
- R3: Mode codes 1 and 7 are stored and driven as 0 (SD/legacy), and the register reads them back as 0.
- R4: A write with bit 15 clear stores bits 13:8 into the readable tap field and leaves `tap_o` unchanged.
- R5: A write with bit 15 set makes bit 15 read 1 for exactly UPD_LAT cycles after the write edge, after which it reads 0.
- R6: `tap_o` changes only on the edge where a pending update completes. It takes the tap field held just before that edge.
- R7: An applied request v gives tap v when v < TAP_COUNT (43) and tap v - TAP_COUNT otherwise, so 43 gives 0 and 63 gives 20.
- R8: Bits 7:3, bit 14 and bits 31:16 always read 0.
- R9: A write with bit 15 set while an update is pending restarts the UPD_LAT count. Only the latest field is applied.
- R10: If a write hits the exact completion edge, the completion applies the field held before that write. A write without bit 15 then leaves bit 15 clear. A write with bit 15 restarts a fresh update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read-back of the control word |
| mode_o | output | 3 | Active bus timing mode |
| tap_o | output | 6 | Active receive sampling tap |

## Verification
A software write and the self-clearing completion of a pending update can land on the same clock edge. The bench provokes this by idling exactly UPD_LAT-1 cycles after an update write and then writing on the completion edge. It does this once with bit 15 clear and once with it set. The bench judges the outcome by whether `tap_o` takes the pre-write field, by whether bit 15 is cleared or re-armed, and by the tap value applied after a re-armed update.

// File: rtl/tune_ctrl_pkg.sv
package tune_ctrl_pkg;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 3;
  localparam int TUNE_LSB = 8;
  localparam int TUNE_W   = 6;
  localparam int UPD_BIT  = 15;

  typedef enum logic [MODE_W-1:0] {
    MODE_SD     = 3'd0,
    MODE_SDR    = 3'd2,
    MODE_DDR    = 3'd3,
    MODE_HS200  = 3'd4,
    MODE_HS400  = 3'd5,
    MODE_HS400S = 3'd6
  } bus_mode_e;

  function automatic bus_mode_e legal_mode(input logic [MODE_W-1:0] code);
    case (code)
      3'd2:    return MODE_SDR;
      3'd3:    return MODE_DDR;
      3'd4:    return MODE_HS200;
      3'd5:    return MODE_HS400;
      3'd6:    return MODE_HS400S;
      default: return MODE_SD;
    endcase
  endfunction

  // single fold; valid while 2*taps > 2**TUNE_W
  function automatic logic [TUNE_W-1:0] wrap_tap(input logic [TUNE_W-1:0] req,
                                                 input int unsigned taps);
    if ({1'b0, req} >= (TUNE_W+1)'(taps)) return req - TUNE_W'(taps);
    return req;
  endfunction
endpackage

// File: rtl/bus_mode_regs.sv
module bus_mode_regs
  import tune_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output bus_mode_e         mode_o,
  output logic [TUNE_W-1:0] field_o,
  output logic [DATA_W-1:0] rd_data_o
);
  bus_mode_e         mode_q;
  logic [TUNE_W-1:0] field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_SD;
      field_q <= '0;
    end else if (wr_en_i) begin
      mode_q  <= legal_mode(wr_data_i[MODE_LSB +: MODE_W]);
      field_q <= wr_data_i[TUNE_LSB +: TUNE_W];
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[MODE_LSB +: MODE_W] = mode_q;
    rd_data_o[TUNE_LSB +: TUNE_W] = field_q;
    rd_data_o[UPD_BIT]            = busy_i;
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[DATA_W-1:UPD_BIT], wr_data_i[TUNE_LSB-1:MODE_W],
                            wr_data_i[TUNE_LSB+TUNE_W +: (UPD_BIT-TUNE_LSB-TUNE_W)]};

  assign mode_o  = mode_q;
  assign field_o = field_q;
endmodule

// File: rtl/tune_apply.sv
module tune_apply
  import tune_ctrl_pkg::*;
#(
  parameter int UPD_LAT   = 4,
  parameter int TAP_COUNT = 43
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TUNE_W-1:0] field_i,
  output logic              busy_o,
  output logic [TUNE_W-1:0] tap_o
);
  localparam int CNT_W = $clog2(UPD_LAT + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [TUNE_W-1:0] tap_q;
  logic              done_w;

  assign done_w = busy_q && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(UPD_LAT);
    end else if (busy_q) begin
      busy_q <= !done_w;
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  // completion samples the field as held before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tap_q <= '0;
    else if (done_w) tap_q <= wrap_tap(field_i, TAP_COUNT);
  end

  assign busy_o = busy_q;
  assign tap_o  = tap_q;
endmodule

// File: rtl/tune_ctrl_top.sv
module tune_ctrl_top
  import tune_ctrl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int UPD_LAT   = 4,
  parameter int TAP_COUNT = 43
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [2:0]        mode_o,
  output logic [5:0]        tap_o
);
  bus_mode_e         mode_w;
  logic [TUNE_W-1:0] field_w;
  logic              busy_w;
  logic              start_w;

  assign start_w = wr_en_i && wr_data_i[UPD_BIT];

  bus_mode_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .busy_i   (busy_w),
    .mode_o   (mode_w),
    .field_o  (field_w),
    .rd_data_o
  );

  tune_apply #(.UPD_LAT(UPD_LAT), .TAP_COUNT(TAP_COUNT)) u_apply (
    .clk_i, .rst_ni,
    .start_i (start_w),
    .field_i (field_w),
    .busy_o  (busy_w),
    .tap_o
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/tune_ctrl_chk.sv
module tune_ctrl_chk
  import tune_ctrl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int UPD_LAT   = 4,
  parameter int TAP_COUNT = 43
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [2:0]        mode_o,
  input logic [5:0]        tap_o
);
  localparam int RW = $clog2(UPD_LAT + 1) + 1;
  localparam logic [DATA_W-1:0] LIVE_MASK =
    DATA_W'((1 << UPD_BIT) | (((1 << TUNE_W) - 1) << TUNE_LSB) | ((1 << MODE_W) - 1));

  logic          busy;
  logic          start;
  logic [RW-1:0] run_q;

  assign busy  = rd_data_o[UPD_BIT];
  assign start = wr_en_i && wr_data_i[UPD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       run_q <= '0;
    else if (start)                    run_q <= '0;
    else if (busy && run_q != '1)      run_q <= run_q + RW'(1);
  end

  assert_mode_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 3'd1) && (mode_o != 3'd7));
  assert_mode_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mode_o == 3'(legal_mode($past(wr_data_i[2:0]))));
  assert_tap_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o < 6'(TAP_COUNT));
  assert_tap_on_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tap_o) |-> ($past(busy) && $past(run_q) == RW'(UPD_LAT - 1)));
  assert_busy_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy) && !busy) |-> $past(run_q) == RW'(UPD_LAT - 1));
  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);
  assert_rsv_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~LIVE_MASK) == '0);
endmodule

bind tune_ctrl_top tune_ctrl_chk #(.DATA_W(DATA_W), .UPD_LAT(UPD_LAT), .TAP_COUNT(TAP_COUNT)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o, .mode_o, .tap_o
);

// File: tb/sim_tune_ctrl_top.sv
module sim_tune_ctrl_top;
  localparam int DW  = 32;
  localparam int LAT = 4;
  localparam int TC  = 43;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [2:0]    mode;
  logic [5:0]    tap;

  int checks = 0;
  int errors = 0;
  logic [2:0] e_mode = '0;
  logic [5:0] e_field = '0;
  logic [5:0] e_tap = '0;

  always #2.5 clk = ~clk;

  tune_ctrl_top #(.DATA_W(DW), .UPD_LAT(LAT), .TAP_COUNT(TC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .mode_o(mode), .tap_o(tap)
  );

  function automatic logic [DW-1:0] word(input logic upd, input logic [5:0] f, input logic [2:0] m);
    return DW'({upd, 1'b0, f, 5'b0, m});
  endfunction

  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m == 3'd1 || m == 3'd7) ? 3'd0 : m;
  endfunction

  function automatic logic [5:0] fold_tap(input int v);
    return 6'((v >= TC) ? v - TC : v);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic state_chk(input string req, input logic busy);
    logic [DW-1:0] er;
    er = word(busy, e_field, e_mode);
    chk(rd_data === er, req, rd_data, er);
    chk(tap === e_tap, req, DW'(tap), DW'(e_tap));
    chk(mode === e_mode, req, DW'(mode), DW'(e_mode));
  endtask

  // caller sits at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [DW-1:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pend_then_apply(input string req, input int new_tap);
    for (int i = 0; i < LAT; i++) begin
      state_chk(req, 1'b1);
      @(negedge clk);
    end
    e_tap = 6'(new_tap);
    state_chk(req, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    state_chk("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    state_chk("R1", 1'b0);

    // R2 R3: every mode code
    for (int m = 0; m < 8; m++) begin
      wr(word(1'b0, e_field, 3'(m)));
      e_mode = fold_mode(3'(m));
      state_chk((m == 1 || m == 7) ? "R3" : "R2", 1'b0);
    end

    // R4: field write without update leaves tap
    wr(word(1'b0, 6'd17, 3'd4));
    e_mode = 3'd4; e_field = 6'd17;
    for (int i = 0; i < LAT + 2; i++) begin
      state_chk("R4", 1'b0);
      @(negedge clk);
    end

    // R5 R6 R7: every tune request
    for (int v = 0; v < 64; v++) begin
      wr(word(1'b1, 6'(v), e_mode));
      e_field = 6'(v);
      pend_then_apply((v >= TC) ? "R7" : "R5_R6", fold_tap(v));
    end

    // R8: all ones
    wr('1);
    e_mode = 3'd0; e_field = 6'd63;
    pend_then_apply("R8", fold_tap(63));
    chk(tap === 6'd20, "R7", DW'(tap), 20);

    // R9: restart while pending
    wr(word(1'b1, 6'd5, 3'd2));
    e_mode = 3'd2; e_field = 6'd5;
    state_chk("R9", 1'b1);
    @(negedge clk);
    wr(word(1'b1, 6'd9, 3'd2));
    e_field = 6'd9;
    pend_then_apply("R9", 9);

    // R10a: plain write on completion edge
    wr(word(1'b1, 6'd30, 3'd3));
    e_mode = 3'd3; e_field = 6'd30;
    repeat (LAT - 1) @(negedge clk);
    wr(word(1'b0, 6'd44, 3'd3));
    e_field = 6'd44; e_tap = 6'd30;
    state_chk("R10", 1'b0);
    repeat (LAT + 1) @(negedge clk);
    state_chk("R10", 1'b0);

    // R10b: update write on completion edge
    wr(word(1'b1, 6'd12, 3'd5));
    e_mode = 3'd5; e_field = 6'd12;
    repeat (LAT - 1) @(negedge clk);
    wr(word(1'b1, 6'd50, 3'd5));
    e_field = 6'd50; e_tap = 6'd12;
    pend_then_apply("R10", fold_tap(50));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule